// File: doc/BRIEF.md
# Chopper Acquisition Timing Sequencer

This block sets the timing of a chopper-stabilized measurement front end. It produces a square phase signal for the modulator and demodulator. It also produces an ADC input polarity signal that flips once per complete chopper cycle, which is half the chopper rate. Each chopper half begins with a blanking interval that lets the front end settle. After that interval the block emits conversion-start pulses grouped into sample blocks, for on-chip averaging. A block is issued only if all of it fits before the half ends. The count of whole blocks therefore follows from the half length, the settling time, the conversion period and the block length. A single-block mode limits each half to at most one block. This keeps result readout clear of the next conversion window.

Every conversion pulse carries a tag giving the half (first or second), the polarity state and the block index within the half. All sample counters restart at every half boundary, so sample indexing cannot drift against the chopper. All timing settings are clock-cycle counts. A start pulse loads the settings and begins a fresh cycle. An update strobe parks new settings in a shadow set, which takes effect only when the current chopper cycle completes.

Top module: `chopper_seq`

## Requirements
- R1: In the cycle that follows the clock edge capturing `startPulse`, `modPhase` and `adcInvert` are 0, the half has just begun (offset 0), and the settings on the `cfg*` inputs are in force.
- R2: `modPhase` flips every H cycles, where H is the half-period count. The first flip is seen at offset H after start.
- R3: `adcInvert` flips only where `modPhase` goes from 1 to 0, so its period is 4H cycles.
- R4: In each half, `convStart` stays low for offsets 0 to S-1, where S is the settling count.
- R5: With conversion period P and block length B, pulses occur at offsets S + k·B·P + j·P for j < B and k < N, where N = floor((H−S)/(B·P)). Exactly N·B pulses occur per half, and counting restarts in every half.
- R6: With `cfgSingleBlock` = 1, N is limited to at most 1.
- R7: Every `convStart` pulse lasts one cycle. During the pulse, `tagHalf` equals the half index (0 = first), `tagInvert` equals `adcInvert`, and `tagBlock` equals k.
- R8: While running, `cfgError` is 1 exactly when H = 0, P < 2, B = 0 or S ≥ H. No pulses are issued in that case, but the phase outputs keep toggling when H > 0.
- R9: Settings captured by `cfgUpdate` take effect at the first edge where `modPhase` falls after the capture. The current cycle completes unchanged, and later changes on the `cfg*` inputs are ignored.
- R10: After the edge capturing `stopPulse`, `modPhase`, `adcInvert`, `convStart` and `cfgError` are all 0 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Load settings and begin a fresh chopper cycle |
| stopPulse | input | 1 | Halt sequencing |
| cfgUpdate | input | 1 | Capture settings into the shadow set |
| cfgHalfPeriod | input | CNT_W | Half-period H in cycles |
| cfgSettle | input | CNT_W | Settling blank S in cycles |
| cfgConvPeriod | input | CNT_W | Conversion period P in cycles |
| cfgBlockLen | input | LEN_W | Conversions per block B |
| cfgSingleBlock | input | 1 | At most one block per half |
| modPhase | output | 1 | Modulator/demodulator phase |
| adcInvert | output | 1 | ADC input polarity switch |
| convStart | output | 1 | One-cycle conversion start |
| tagHalf | output | 1 | Half index of the current sample |
| tagInvert | output | 1 | Polarity state of the current sample |
| tagBlock | output | IDX_W | Block index within the half |
| cfgError | output | 1 | Active settings admit no conversion |

## Verification
Each of the block's outputs is decoded from registers that update on the edge capturing a strobe, so every result is due in the cycle right after that edge, with no extra delay. The bench drives inputs and samples outputs on falling edges. It counts time t from the first falling edge after the start edge. From t it derives the half index t/H and the offset t mod H, and predicts every output for that cycle using the requirement formulas. For the update test, the switch is expected at t = 2H of the old settings, and the new timing base starts there.

// File: rtl/chopper_seq_pkg.sv
package chopper_seq_pkg;

  // Strobes from control to datapath, valid for one cycle each.
  typedef struct packed {
    logic clear;     // start or stop: zero every counter
    logic tick;      // running cycle, advance the half counter
    logic halfEnd;   // last cycle of a half
    logic winStep;   // cycle inside the sampling window
    logic slotEnd;   // last cycle of a conversion slot
    logic blockEnd;  // last conversion of a block
    logic fire;      // conversion start this cycle
  } seqStrobeT;

endpackage

// File: rtl/chopper_seq_ctrl.sv
module chopper_seq_ctrl
  import chopper_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 8,
  parameter int IDX_W = 8,
  localparam int SPAN_W = CNT_W + LEN_W,
  localparam int SUM_W  = SPAN_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              stopPulse,
  input  logic              cfgUpdate,
  input  logic [CNT_W-1:0]  cfgHalfPeriod,
  input  logic [CNT_W-1:0]  cfgSettle,
  input  logic [CNT_W-1:0]  cfgConvPeriod,
  input  logic [LEN_W-1:0]  cfgBlockLen,
  input  logic              cfgSingleBlock,
  input  logic [CNT_W-1:0]  phCnt,
  input  logic [CNT_W-1:0]  slotCnt,
  input  logic [LEN_W-1:0]  sampIdx,
  input  logic [IDX_W-1:0]  blkIdx,
  input  logic [SUM_W-1:0]  blkBase,
  input  logic              modPhase,
  output seqStrobeT         strb,
  output logic [SPAN_W-1:0] span,
  output logic              cfgError
);

  logic             running, pend;
  logic [CNT_W-1:0] aHalf, aSettle, aPer, sHalf, sSettle, sPer;
  logic [LEN_W-1:0] aLen, sLen;
  logic             aSingle, sSingle;
  logic             bad, fits, inWin, cycEnd;

  assign cycEnd = strb.halfEnd & modPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0; pend <= 1'b0;
      aHalf <= '0; aSettle <= '0; aPer <= '0; aLen <= '0; aSingle <= 1'b0;
      sHalf <= '0; sSettle <= '0; sPer <= '0; sLen <= '0; sSingle <= 1'b0;
    end else if (startPulse) begin
      running <= 1'b1;
      pend    <= 1'b0;
      aHalf   <= cfgHalfPeriod; aSettle <= cfgSettle; aPer <= cfgConvPeriod;
      aLen    <= cfgBlockLen;   aSingle <= cfgSingleBlock;
    end else begin
      if (stopPulse) running <= 1'b0;
      if (cycEnd && pend) begin
        aHalf <= sHalf; aSettle <= sSettle; aPer <= sPer;
        aLen  <= sLen;  aSingle <= sSingle;
        pend  <= 1'b0;
      end
      if (cfgUpdate) begin
        sHalf <= cfgHalfPeriod; sSettle <= cfgSettle; sPer <= cfgConvPeriod;
        sLen  <= cfgBlockLen;   sSingle <= cfgSingleBlock;
        pend  <= 1'b1;
      end
    end
  end

  assign bad  = (aHalf == '0) | (aPer < CNT_W'(2)) | (aLen == '0) | (aSettle >= aHalf);
  assign span = SPAN_W'(aPer) * SPAN_W'(aLen);
  assign fits = (SUM_W'(aSettle) + blkBase + SUM_W'(span)) <= SUM_W'(aHalf);
  assign inWin = phCnt >= aSettle;
  assign cfgError = running & bad;

  always_comb begin
    strb.clear    = startPulse | stopPulse;
    strb.tick     = running & ~strb.clear;
    strb.halfEnd  = strb.tick & (phCnt == aHalf - 1'b1);
    strb.winStep  = strb.tick & ~strb.halfEnd & inWin;
    strb.slotEnd  = slotCnt == aPer - 1'b1;
    strb.blockEnd = sampIdx == aLen - 1'b1;
    strb.fire     = running & ~bad & inWin & (slotCnt == '0) & fits
                    & ~(aSingle & (blkIdx != '0));
  end

  AST_FIRE_IN_HALF: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |-> (phCnt < aHalf) && (sampIdx < aLen)); // R5

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && !startPulse) |=> !strb.fire); // R7

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!startPulse && !cycEnd) |=> $stable(aHalf) && $stable(aSettle) && $stable(aPer)); // R9

endmodule

// File: rtl/chopper_seq_dp.sv
module chopper_seq_dp
  import chopper_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 8,
  parameter int IDX_W = 8,
  localparam int SPAN_W = CNT_W + LEN_W,
  localparam int SUM_W  = SPAN_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strb,
  input  logic [SPAN_W-1:0] span,
  output logic [CNT_W-1:0]  phCnt,
  output logic [CNT_W-1:0]  slotCnt,
  output logic [LEN_W-1:0]  sampIdx,
  output logic [IDX_W-1:0]  blkIdx,
  output logic [SUM_W-1:0]  blkBase,
  output logic              modPhase,
  output logic              adcInvert,
  output logic              convStart
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phCnt <= '0; slotCnt <= '0; sampIdx <= '0; blkIdx <= '0; blkBase <= '0;
      modPhase <= 1'b0; adcInvert <= 1'b0;
    end else if (strb.clear) begin
      phCnt <= '0; slotCnt <= '0; sampIdx <= '0; blkIdx <= '0; blkBase <= '0;
      modPhase <= 1'b0; adcInvert <= 1'b0;
    end else if (strb.halfEnd) begin
      phCnt    <= '0;
      modPhase <= ~modPhase;
      if (modPhase) adcInvert <= ~adcInvert;
      slotCnt <= '0; sampIdx <= '0; blkIdx <= '0; blkBase <= '0;
    end else if (strb.tick) begin
      phCnt <= phCnt + 1'b1;
      if (strb.winStep) begin
        if (strb.slotEnd) begin
          slotCnt <= '0;
          if (strb.blockEnd) begin
            sampIdx <= '0;
            if (blkIdx != '1) blkIdx <= blkIdx + 1'b1;
            blkBase <= blkBase + SUM_W'(span);
          end else begin
            sampIdx <= sampIdx + 1'b1;
          end
        end else begin
          slotCnt <= slotCnt + 1'b1;
        end
      end
    end
  end

  assign convStart = strb.fire;

  AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (phCnt == '0) && !modPhase && !adcInvert); // R1

  AST_INVERT_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clear && strb.halfEnd && modPhase) |=> (adcInvert != $past(adcInvert))); // R3

  AST_INVERT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clear && !(strb.halfEnd && modPhase)) |=> $stable(adcInvert)); // R3

endmodule

// File: rtl/chopper_seq.sv
module chopper_seq
  import chopper_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             stopPulse,
  input  logic             cfgUpdate,
  input  logic [CNT_W-1:0] cfgHalfPeriod,
  input  logic [CNT_W-1:0] cfgSettle,
  input  logic [CNT_W-1:0] cfgConvPeriod,
  input  logic [LEN_W-1:0] cfgBlockLen,
  input  logic             cfgSingleBlock,
  output logic             modPhase,
  output logic             adcInvert,
  output logic             convStart,
  output logic             tagHalf,
  output logic             tagInvert,
  output logic [IDX_W-1:0] tagBlock,
  output logic             cfgError
);

  localparam int SPAN_W = CNT_W + LEN_W;
  localparam int SUM_W  = SPAN_W + 2;

  seqStrobeT         strb;
  logic [SPAN_W-1:0] span;
  logic [CNT_W-1:0]  phCnt, slotCnt;
  logic [LEN_W-1:0]  sampIdx;
  logic [IDX_W-1:0]  blkIdx;
  logic [SUM_W-1:0]  blkBase;

  chopper_seq_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
    .cfgUpdate(cfgUpdate), .cfgHalfPeriod(cfgHalfPeriod), .cfgSettle(cfgSettle),
    .cfgConvPeriod(cfgConvPeriod), .cfgBlockLen(cfgBlockLen),
    .cfgSingleBlock(cfgSingleBlock), .phCnt(phCnt), .slotCnt(slotCnt),
    .sampIdx(sampIdx), .blkIdx(blkIdx), .blkBase(blkBase), .modPhase(modPhase),
    .strb(strb), .span(span), .cfgError(cfgError)
  );

  chopper_seq_dp #(.CNT_W(CNT_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .span(span), .phCnt(phCnt),
    .slotCnt(slotCnt), .sampIdx(sampIdx), .blkIdx(blkIdx), .blkBase(blkBase),
    .modPhase(modPhase), .adcInvert(adcInvert), .convStart(convStart)
  );

  assign tagHalf   = modPhase;
  assign tagInvert = adcInvert;
  assign tagBlock  = blkIdx;

endmodule

// File: tb/chopper_seq_test.sv
module chopper_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0, stopPulse = 1'b0, cfgUpdate = 1'b0;
  logic [15:0] cfgHalfPeriod = '0, cfgSettle = '0, cfgConvPeriod = '0;
  logic [7:0]  cfgBlockLen = '0;
  logic        cfgSingleBlock = 1'b0;
  logic        modPhase, adcInvert, convStart, tagHalf, tagInvert, cfgError;
  logic [7:0]  tagBlock;
  int          nChk = 0, nBad = 0;

  always #10 clk = ~clk;

  chopper_seq uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
    .cfgUpdate(cfgUpdate), .cfgHalfPeriod(cfgHalfPeriod), .cfgSettle(cfgSettle),
    .cfgConvPeriod(cfgConvPeriod), .cfgBlockLen(cfgBlockLen),
    .cfgSingleBlock(cfgSingleBlock), .modPhase(modPhase), .adcInvert(adcInvert),
    .convStart(convStart), .tagHalf(tagHalf), .tagInvert(tagInvert),
    .tagBlock(tagBlock), .cfgError(cfgError)
  );

  // columns: H, S, P, B, single, expected blocks per half, expected error
  localparam int NV = 8;
  localparam int VEC [NV][7] = '{
    '{40,  5, 3, 4, 0, 2, 0},
    '{40,  4, 3, 4, 0, 3, 0},
    '{40,  4, 3, 4, 1, 1, 0},
    '{20,  0, 2, 1, 0, 10, 0},
    '{16, 16, 2, 1, 0, 0, 1},
    '{30, 29, 2, 1, 0, 0, 0},
    '{20,  2, 1, 3, 0, 0, 1},
    '{50,  2, 4, 2, 0, 6, 0}
  };

  task automatic chk(string req, int act, int exp, string what);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expBlk(int off, int h, int s, int p, int b, int sg);
    int span, n, d;
    if (h == 0 || p < 2 || b == 0 || s >= h) return -1;
    span = p * b;
    n = (h - s) / span;
    if (sg != 0 && n > 1) n = 1;
    if (off < s) return -1;
    d = off - s;
    if (d % p != 0) return -1;
    if (d / span >= n) return -1;
    return d / span;
  endfunction

  task automatic checkCycle(int t, int h, int s, int p, int b, int sg, int invBase, string tag);
    int hi, off, k;
    string rp, ri, rc;
    hi  = t / h;
    off = t % h;
    k   = expBlk(off, h, s, p, b, sg);
    rp = (tag != "") ? tag : ((t == 0) ? "R1" : "R2");
    ri = (tag != "") ? tag : ((t == 0) ? "R1" : "R3");
    rc = (tag != "") ? tag : ((off < s) ? "R4" : "R5");
    chk(rp, int'(modPhase), hi % 2, "modPhase");
    chk(ri, int'(adcInvert), invBase ^ ((hi / 2) % 2), "adcInvert");
    chk(rc, int'(convStart), (k >= 0) ? 1 : 0, $sformatf("convStart off %0d", off));
    if (k >= 0 && convStart) begin
      chk("R7", int'(tagHalf), hi % 2, "tagHalf");
      chk("R7", int'(tagInvert), invBase ^ ((hi / 2) % 2), "tagInvert");
      chk("R7", int'(tagBlock), k, "tagBlock");
    end
  endtask

  task automatic setCfg(int h, int s, int p, int b, int sg);
    cfgHalfPeriod = 16'(h); cfgSettle = 16'(s); cfgConvPeriod = 16'(p);
    cfgBlockLen = 8'(b); cfgSingleBlock = 1'(sg);
  endtask

  task automatic runVec(int h, int s, int p, int b, int sg, int en, int ee);
    int pc0, pc1;
    @(negedge clk);
    setCfg(h, s, p, b, sg);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    pc0 = 0; pc1 = 0;
    chk("R8", int'(cfgError), ee, "cfgError");
    for (int t = 0; t < 4 * h; t++) begin
      checkCycle(t, h, s, p, b, sg, 0, "");
      if (convStart && t < h) pc0++;
      if (convStart && t >= h && t < 2 * h) pc1++;
      @(negedge clk);
    end
    chk((sg != 0) ? "R6" : "R5", pc0, en * b, "pulses in first half");
    chk((sg != 0) ? "R6" : "R5", pc1, en * b, "pulses in second half");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R10", int'(convStart), 0, "reset convStart");
    chk("R10", int'(modPhase), 0, "reset modPhase");
    chk("R10", int'(adcInvert), 0, "reset adcInvert");
    chk("R8", int'(cfgError), 0, "reset cfgError");

    for (int v = 0; v < NV; v++)
      runVec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);

    // R9: shadow update applied only at the next full-cycle boundary
    @(negedge clk);
    setCfg(40, 5, 3, 4, 0);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    for (int t = 0; t < 80; t++) begin
      checkCycle(t, 40, 5, 3, 4, 0, 0, (t > 10) ? "R9" : "");
      if (t == 10) begin
        setCfg(20, 2, 2, 3, 0);
        cfgUpdate = 1'b1;
      end
      if (t == 11) begin
        cfgUpdate = 1'b0;
        setCfg(7, 1, 5, 1, 0);
      end
      @(negedge clk);
    end
    for (int t = 0; t < 80; t++) begin
      checkCycle(t, 20, 2, 2, 3, 0, 1, "R9");
      @(negedge clk);
    end

    // R10: stop
    stopPulse = 1'b1;
    @(negedge clk);
    stopPulse = 1'b0;
    for (int t = 0; t < 12; t++) begin
      chk("R10", int'(modPhase), 0, "modPhase after stop");
      chk("R10", int'(adcInvert), 0, "adcInvert after stop");
      chk("R10", int'(convStart), 0, "convStart after stop");
      chk("R10", int'(cfgError), 0, "cfgError after stop");
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule